// File: doc/BRIEF.md
# Flash Self-Programming Command Arming Register

This block is an 8-bit control and status register for a small processor core that updates its own program flash. Software arms a command with a single register write that sets a command bit and the enable bit together. The write opens a short window. If the core issues the matching program-memory strobe inside that window, the block turns it into exactly one request pulse to the flash controller. A store strobe can produce a page erase or a page write. A load strobe can produce a signature-row read or a lock/fuse read. If no strobe arrives in time, the armed bits clear themselves.

During a page erase or page write, the block holds the core halted until the flash controller signals completion. The block also produces a one-cycle pulse that empties the temporary page buffer when software asks for it while the buffer is being filled.

The controller is a four-state machine:
- `ST_IDLE`: nothing is armed. A valid register write is accepted only here.
- `ST_ARM_PAGE`: an erase or write is armed and waits for a store strobe.
- `ST_ARM_READ`: a lock/fuse or signature read is armed and waits for a load strobe.
- `ST_BUSY`: a page operation runs and the core is halted.

The transitions are:
- `ST_IDLE`→`ST_ARM_PAGE` on an arming write for erase or write.
- `ST_IDLE`→`ST_ARM_READ` on an arming write for a read.
- `ST_ARM_PAGE`→`ST_BUSY` on a store strobe.
- `ST_ARM_PAGE`→`ST_IDLE` when the window expires.
- `ST_ARM_READ`→`ST_IDLE` on a load strobe or on window expiry.
- `ST_BUSY`→`ST_IDLE` on `op_done`.

Top module: `selfprog_ctl`

## Requirements
- R1: After reset `reg_rdata` is 0x00 and `cpu_halt` is low. Bits 7:6 of `reg_rdata` always read 0, and writes to them have no effect.
- R2: Writing 0x03 (erase bit 1 plus enable bit 0) arms a page erase, and `reg_rdata` reads 0x03. A `spm_strobe` sampled on any of the next four clock edges gives one `req_erase` pulse in the cycle after that edge.
- R3: Writing 0x05 (write bit 2 plus enable) arms a page write in the same way. A store strobe on any of the next four edges, the fourth included, gives one `req_write` pulse.
- R4: If no store strobe arrives on the four edges after a page arming write, the register reads 0x00 after the fourth edge, and a later store strobe produces no request.
- R5: `cpu_halt` rises in the cycle after an accepted store strobe and stays high until the edge that samples `op_done`. At that edge it falls and the register returns to 0x00.
- R6: Writing 0x09 (lock/fuse bit 3 plus enable) arms a read. A `lpm_strobe` on any of the next three edges gives one `req_lock_rd` pulse when `z_lsb` is 0, or one `req_fuse_rd` pulse when `z_lsb` is 1. With no strobe, the register reads 0x00 after the third edge.
- R7: Writing 0x21 (signature bit 5 plus enable) arms a signature read. A load strobe on one of the next three edges gives one `req_sig_rd` pulse. A store strobe while it is armed has no effect and does not disarm it.
- R8: A write with bit 4 set gives one `buf_clear` pulse in the next cycle when `pg_fill_active` is high at that write, and no pulse otherwise. Bit 4 reads 1 for that one cycle only.
- R9: A write with bit 0 clear arms nothing: the register reads 0x00 and later strobes produce no request.
- R10: When several command bits are written with enable, only one is kept, with priority erase > write > lock/fuse > signature. For example, 0x07 reads back as 0x03 and 0x2D reads back as 0x05.
- R11: Register writes are ignored while a command is armed or a page operation is running.
- R12: At most one of the six pulse outputs is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| spm_strobe | input | 1 | Store-to-program-memory strobe from the core |
| lpm_strobe | input | 1 | Load-from-program-memory strobe from the core |
| z_lsb | input | 1 | Bit 0 of the Z pointer (0 selects lock, 1 selects fuse) |
| pg_fill_active | input | 1 | Temporary page buffer is being filled |
| op_done | input | 1 | Flash controller has finished the page operation |
| req_erase | output | 1 | Page erase request pulse |
| req_write | output | 1 | Page write request pulse |
| req_lock_rd | output | 1 | Lock-bit read request pulse |
| req_fuse_rd | output | 1 | Fuse-bit read request pulse |
| req_sig_rd | output | 1 | Signature-row read request pulse |
| buf_clear | output | 1 | Page buffer discard pulse |
| cpu_halt | output | 1 | Core halt during page operations |

## Verification
The arming value in `reg_rdata` is visible in the cycle after the write edge. A request pulse, and the rise of `cpu_halt`, appear in the cycle after the edge that samples the strobe. An expired window shows as 0x00 after the fourth edge for page commands and after the third edge for reads. The bench drives every input on the falling edge and reads every output on the falling edge that follows the rising edge under test. Because of this, each check samples exactly one register stage after its stimulus. Window limits are checked on both the last edge that is accepted and the first edge that is not.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM_PAGE,
        ST_ARM_READ,
        ST_BUSY
    } sp_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ERASE,
        CMD_WRITE,
        CMD_FUSE,
        CMD_SIG
    } sp_cmd_t;

    // bit positions inside the control register
    localparam int BIT_EN     = 0;
    localparam int BIT_ERASE  = 1;
    localparam int BIT_WRITE  = 2;
    localparam int BIT_FUSE   = 3;
    localparam int BIT_CLRBUF = 4;
    localparam int BIT_SIG    = 5;
    localparam int LIVE_BITS  = 6;

    function automatic logic cmd_is_page(sp_cmd_t c);
        return (c == CMD_ERASE) || (c == CMD_WRITE);
    endfunction

    function automatic logic cmd_is_read(sp_cmd_t c);
        return (c == CMD_FUSE) || (c == CMD_SIG);
    endfunction

endpackage

// File: rtl/selfprog_decode.sv
module selfprog_decode
    import selfprog_pkg::*;
(
    input  logic [LIVE_BITS-1:0] wdata,
    output sp_cmd_t              cmd,
    output logic                 clr_req
);

    // priority: erase, then write, then lock/fuse read, then signature read
    always_comb begin
        cmd = CMD_NONE;
        if (wdata[BIT_EN]) begin
            if (wdata[BIT_ERASE]) begin
                cmd = CMD_ERASE;
            end else if (wdata[BIT_WRITE]) begin
                cmd = CMD_WRITE;
            end else if (wdata[BIT_FUSE]) begin
                cmd = CMD_FUSE;
            end else if (wdata[BIT_SIG]) begin
                cmd = CMD_SIG;
            end
        end
    end

    assign clr_req = wdata[BIT_CLRBUF];

endmodule

// File: rtl/selfprog_window.sv
module selfprog_window #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] last_idx,
    output logic             at_last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == last_idx);

endmodule

// File: rtl/selfprog_pulse.sv
module selfprog_pulse
    import selfprog_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fire_page,
    input  logic    fire_read,
    input  sp_cmd_t cmd,
    input  logic    z_sel,
    input  logic    clr_hit,
    output logic    req_erase,
    output logic    req_write,
    output logic    req_lock_rd,
    output logic    req_fuse_rd,
    output logic    req_sig_rd,
    output logic    buf_clear
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_erase   <= 1'b0;
            req_write   <= 1'b0;
            req_lock_rd <= 1'b0;
            req_fuse_rd <= 1'b0;
            req_sig_rd  <= 1'b0;
            buf_clear   <= 1'b0;
        end else begin
            req_erase   <= fire_page && (cmd == CMD_ERASE);
            req_write   <= fire_page && (cmd == CMD_WRITE);
            req_lock_rd <= fire_read && (cmd == CMD_FUSE) && !z_sel;
            req_fuse_rd <= fire_read && (cmd == CMD_FUSE) && z_sel;
            req_sig_rd  <= fire_read && (cmd == CMD_SIG);
            buf_clear   <= clr_hit;
        end
    end

endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
    import selfprog_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int PG_WIN = 4,
    parameter int RD_WIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             spm_strobe,
    input  logic             lpm_strobe,
    input  logic             z_lsb,
    input  logic             pg_fill_active,
    input  logic             op_done,
    output logic             req_erase,
    output logic             req_write,
    output logic             req_lock_rd,
    output logic             req_fuse_rd,
    output logic             req_sig_rd,
    output logic             buf_clear,
    output logic             cpu_halt
);

    localparam int MAX_WIN = (PG_WIN > RD_WIN) ? PG_WIN : RD_WIN;
    localparam int CNT_W   = $clog2(MAX_WIN) + 1;

    sp_state_t        state_q, state_d;
    sp_cmd_t          cmd_q, dec_cmd;
    logic             clrbuf_q, dec_clr;
    logic             wr_ok, at_last, fire_page, fire_read;
    logic [CNT_W-1:0] last_idx;
    logic             rsvd_unused;

    assign rsvd_unused = ^reg_wdata[REG_W-1:LIVE_BITS];

    selfprog_decode u_decode (
        .wdata   (reg_wdata[LIVE_BITS-1:0]),
        .cmd     (dec_cmd),
        .clr_req (dec_clr)
    );

    assign wr_ok     = reg_we && (state_q == ST_IDLE);
    assign fire_page = (state_q == ST_ARM_PAGE) && spm_strobe;
    assign fire_read = (state_q == ST_ARM_READ) && lpm_strobe;
    assign last_idx  = (state_q == ST_ARM_PAGE) ? CNT_W'(PG_WIN - 1)
                                                : CNT_W'(RD_WIN - 1);

    selfprog_window #(.CNT_W(CNT_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_ok),
        .last_idx (last_idx),
        .at_last  (at_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_ok && cmd_is_page(dec_cmd)) begin
                    state_d = ST_ARM_PAGE;
                end else if (wr_ok && cmd_is_read(dec_cmd)) begin
                    state_d = ST_ARM_READ;
                end
            end
            ST_ARM_PAGE: begin
                if (spm_strobe) begin
                    state_d = ST_BUSY;
                end else if (at_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ARM_READ: begin
                if (lpm_strobe || at_last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (op_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cmd_q    <= CMD_NONE;
            clrbuf_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            clrbuf_q <= wr_ok && dec_clr;
            if (state_d == ST_IDLE) begin
                cmd_q <= CMD_NONE;
            end else if (state_q == ST_IDLE) begin
                cmd_q <= dec_cmd;
            end
        end
    end

    selfprog_pulse u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_page   (fire_page),
        .fire_read   (fire_read),
        .cmd         (cmd_q),
        .z_sel       (z_lsb),
        .clr_hit     (wr_ok && dec_clr && pg_fill_active),
        .req_erase   (req_erase),
        .req_write   (req_write),
        .req_lock_rd (req_lock_rd),
        .req_fuse_rd (req_fuse_rd),
        .req_sig_rd  (req_sig_rd),
        .buf_clear   (buf_clear)
    );

    // outputs seen by software and the core
    always_comb begin
        reg_rdata             = '0;
        reg_rdata[BIT_EN]     = (cmd_q != CMD_NONE);
        reg_rdata[BIT_ERASE]  = (cmd_q == CMD_ERASE);
        reg_rdata[BIT_WRITE]  = (cmd_q == CMD_WRITE);
        reg_rdata[BIT_FUSE]   = (cmd_q == CMD_FUSE);
        reg_rdata[BIT_SIG]    = (cmd_q == CMD_SIG);
        reg_rdata[BIT_CLRBUF] = clrbuf_q;
        cpu_halt              = (state_q == ST_BUSY);
    end

endmodule

// File: rtl/selfprog_ctl_chk.sv
module selfprog_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       spm_strobe,
    input logic       lpm_strobe,
    input logic       op_done,
    input logic       req_erase,
    input logic       req_write,
    input logic       req_lock_rd,
    input logic       req_fuse_rd,
    input logic       req_sig_rd,
    input logic       buf_clear,
    input logic       cpu_halt
);

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:6] == 2'b00);

    p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_erase, req_write, req_lock_rd, req_fuse_rd, req_sig_rd, buf_clear}));

    p_erase_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_erase |=> !req_erase);

    p_write_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_write |=> !req_write);

    p_page_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_erase || req_write) |-> cpu_halt);

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !op_done) |=> cpu_halt);

    p_no_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_wdata[0] && !reg_rdata[0]) |=> ((reg_rdata & 8'h2F) == 8'h00));

    p_busy_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && reg_we && !op_done) |=> $stable(reg_rdata));

endmodule

bind selfprog_ctl selfprog_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .spm_strobe  (spm_strobe),
    .lpm_strobe  (lpm_strobe),
    .op_done     (op_done),
    .req_erase   (req_erase),
    .req_write   (req_write),
    .req_lock_rd (req_lock_rd),
    .req_fuse_rd (req_fuse_rd),
    .req_sig_rd  (req_sig_rd),
    .buf_clear   (buf_clear),
    .cpu_halt    (cpu_halt)
);

// File: tb/selfprog_ctl_test.sv
`timescale 1ns/1ps
module selfprog_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spm_strobe = 1'b0;
    logic       lpm_strobe = 1'b0;
    logic       z_lsb = 1'b0;
    logic       pg_fill_active = 1'b0;
    logic       op_done = 1'b0;
    logic       req_erase, req_write, req_lock_rd, req_fuse_rd, req_sig_rd, buf_clear;
    logic       cpu_halt;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // pulse codes: {buf_clear, sig, fuse, lock, write, erase}
    localparam logic [5:0] E_ERASE = 6'b000001;
    localparam logic [5:0] E_WRITE = 6'b000010;
    localparam logic [5:0] E_LOCK  = 6'b000100;
    localparam logic [5:0] E_FUSE  = 6'b001000;
    localparam logic [5:0] E_SIG   = 6'b010000;
    localparam logic [5:0] E_CLR   = 6'b100000;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    selfprog_ctl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .spm_strobe     (spm_strobe),
        .lpm_strobe     (lpm_strobe),
        .z_lsb          (z_lsb),
        .pg_fill_active (pg_fill_active),
        .op_done        (op_done),
        .req_erase      (req_erase),
        .req_write      (req_write),
        .req_lock_rd    (req_lock_rd),
        .req_fuse_rd    (req_fuse_rd),
        .req_sig_rd     (req_sig_rd),
        .buf_clear      (buf_clear),
        .cpu_halt       (cpu_halt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1;
        reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic spm();
        spm_strobe = 1'b1;
        step();
        spm_strobe = 1'b0;
    endtask

    task automatic lpm();
        lpm_strobe = 1'b1;
        step();
        lpm_strobe = 1'b0;
    endtask

    task automatic done();
        op_done = 1'b1;
        step();
        op_done = 1'b0;
    endtask

    task automatic expect_pulse(input logic [5:0] code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    task automatic drain(input string tag);
        step();
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic rd_is(input logic [7:0] e, input string tag);
        chk(reg_rdata == e, tag, reg_rdata, e);
    endtask

    // monitor: every pulse seen must match the head of the queue
    always @(negedge clk) begin
        logic [5:0] seen;
        seen = {buf_clear, req_sig_rd, req_fuse_rd, req_lock_rd, req_write, req_erase};
        if (rst_n && seen != 6'b0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected pulse (R4 R7 R9)", seen, 0);
            end else begin
                chk(seen == exp_q[0], tag_q[0], seen, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rd_is(8'h00, "R1 reset value");
        chk(cpu_halt == 1'b0, "R1 reset halt", cpu_halt, 0);
        rst_n = 1'b1;
        step();

        // reserved bits only, no enable
        wr(8'hC0);
        rd_is(8'h00, "R1 reserved bits read zero");
        drain("R1");

        // R2 erase, strobe on third edge
        wr(8'h03);
        rd_is(8'h03, "R2 erase armed readback");
        step();
        step();
        expect_pulse(E_ERASE, "R2 erase request");
        spm();
        chk(cpu_halt == 1'b1, "R5 halt after strobe", cpu_halt, 1);
        step();
        step();
        chk(cpu_halt == 1'b1, "R5 halt held", cpu_halt, 1);
        done();
        chk(cpu_halt == 1'b0, "R5 halt released", cpu_halt, 0);
        rd_is(8'h00, "R5 cleared on completion");
        drain("R2");

        // R3 write, strobe on fourth edge (last accepted)
        wr(8'h05);
        rd_is(8'h05, "R3 write armed readback");
        step();
        step();
        step();
        expect_pulse(E_WRITE, "R3 write request at edge four");
        spm();
        chk(cpu_halt == 1'b1, "R5 halt on write", cpu_halt, 1);
        done();
        drain("R3");

        // R4 expiry
        wr(8'h05);
        step();
        step();
        step();
        rd_is(8'h05, "R4 still armed at edge three");
        step();
        rd_is(8'h00, "R4 cleared after edge four");
        spm();
        chk(cpu_halt == 1'b0, "R4 late strobe no halt", cpu_halt, 0);
        drain("R4");

        // R6 lock read (z=0), immediate strobe
        z_lsb = 1'b0;
        wr(8'h09);
        rd_is(8'h09, "R6 read armed readback");
        expect_pulse(E_LOCK, "R6 lock read");
        lpm();
        rd_is(8'h00, "R6 cleared after read");
        drain("R6 lock");

        // R6 fuse read (z=1), strobe on third edge
        z_lsb = 1'b1;
        wr(8'h09);
        step();
        step();
        expect_pulse(E_FUSE, "R6 fuse read at edge three");
        lpm();
        drain("R6 fuse");

        // R6 read expiry
        wr(8'h09);
        step();
        step();
        rd_is(8'h09, "R6 armed at edge two");
        step();
        rd_is(8'h00, "R6 cleared after edge three");
        lpm();
        drain("R6 expiry");

        // R7 signature, store strobe ignored
        wr(8'h21);
        spm();
        chk(cpu_halt == 1'b0, "R7 store strobe no halt", cpu_halt, 0);
        rd_is(8'h21, "R7 still armed after store strobe");
        expect_pulse(E_SIG, "R7 signature read");
        lpm();
        drain("R7");

        // R8 clear-buffer with and without fill
        pg_fill_active = 1'b1;
        expect_pulse(E_CLR, "R8 buffer clear pulse");
        wr(8'h10);
        rd_is(8'h10, "R8 bit reads one");
        step();
        rd_is(8'h00, "R8 bit self-clears");
        pg_fill_active = 1'b0;
        wr(8'h10);
        drain("R8 no fill no pulse");

        // R9 commands without enable
        wr(8'h06);
        rd_is(8'h00, "R9 no arm without enable");
        spm();
        chk(cpu_halt == 1'b0, "R9 strobe no halt", cpu_halt, 0);
        drain("R9");

        // R10 priority
        wr(8'h07);
        rd_is(8'h03, "R10 erase wins over write");
        expect_pulse(E_ERASE, "R10 erase only");
        spm();
        done();
        drain("R10 a");
        wr(8'h2D);
        rd_is(8'h05, "R10 write wins over reads");
        expect_pulse(E_WRITE, "R10 write only");
        spm();
        done();
        drain("R10 b");

        // R11 writes while armed and while busy
        z_lsb = 1'b0;
        wr(8'h09);
        wr(8'h03);
        rd_is(8'h09, "R11 write ignored while armed");
        expect_pulse(E_LOCK, "R11 original command kept");
        lpm();
        drain("R11 a");
        wr(8'h03);
        expect_pulse(E_ERASE, "R11 erase");
        spm();
        wr(8'h05);
        rd_is(8'h03, "R11 write ignored while busy");
        chk(cpu_halt == 1'b1, "R11 still halted", cpu_halt, 1);
        done();
        drain("R11 b");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule